// File: doc/BRIEF.md
# Hub Transmit-Hang Watchdog

This block guards a repeater hub against a transmitter that never lets go of the line. It watches the hub's transmit-active signal. If that signal stays asserted without a break for a whole timeout window, the hub's direction control is taken to be hung. The block then drives a fixed-length reset pulse to the hub and to the media-interface units attached to it. It also sets a sticky flag that a status register can expose to software.

The timeout window is a fixed number of bit periods, 8192 by default, which is roughly 3.3 ms at 2.5 Mbps. A rate-select input chooses the clocks-per-bit figure for the slower or the faster line rate, so the window halves when the faster rate is selected. The media-interface resets fire only when the hub is enabled at the moment of timeout; the hub reset fires either way. Once a pulse ends, the counter starts again from zero, so a further timeout needs another full continuous active window.

Top module: `tx_hang_watchdog`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `hubReset`, every `mediaReset` bit and `timeoutFlag` are 0.
- R2: With `rateFast`=0, a timeout occurs on the clock edge that samples `txActive`=1 for the BIT_PERIODS*CLKS_PER_BIT_SLOW-th consecutive time. `hubReset` is high from the cycle that follows that edge. One fewer active sample gives no timeout.
- R3: With `rateFast`=1, the same rule applies with BIT_PERIODS*CLKS_PER_BIT_FAST consecutive samples.
- R4: A single edge that samples `txActive`=0 restarts the count from zero, and `hubReset` cannot rise in the cycle after such an edge.
- R5: Each timeout drives `hubReset` high for exactly PULSE_LEN consecutive cycles.
- R6: When `hubEnable` is 1 on the timeout edge, every `mediaReset` bit pulses together with `hubReset`. When it is 0, all `mediaReset` bits stay 0 for that pulse, while `hubReset` still pulses.
- R7: While the pulse runs, nothing is counted. After the pulse ends, another timeout needs a full fresh window of consecutive active samples. With `txActive` held at 1, pulses therefore start every threshold+PULSE_LEN cycles.
- R8: `timeoutFlag` rises in the same cycle as `hubReset`. It stays at 1 after the pulse ends and after `txActive` drops.
- R9: An edge with `flagClearWr`=1 and `flagClearData`=1 clears `timeoutFlag`. A write with `flagClearData`=0 leaves it unchanged.
- R10: An edge with `swReset`=1 clears `timeoutFlag`. If a timeout happens on the same edge, the flag is set.
- R11: An edge on which `rateFast` differs from its value on the previous edge clears the count. That edge does not count, and a full window at the new rate is needed after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Global synchronous reset, active low |
| rateFast | input | 1 | 1 selects the faster line rate, 0 the slower |
| hubEnable | input | 1 | Hub unit switched on; gates the media-interface resets |
| txActive | input | 1 | Hub transmit-active signal being watched |
| flagClearWr | input | 1 | Write strobe for the flag-clear bit |
| flagClearData | input | 1 | Written bit; 1 clears the timeout flag |
| swReset | input | 1 | Software reset of the timeout flag |
| hubReset | output | 1 | Reset pulse to the hub unit |
| mediaReset | output | MEDIA_UNITS | Reset pulses to the media-interface units |
| timeoutFlag | output | 1 | Sticky timeout indication |

## Verification
The bench builds the block with BIT_PERIODS=8, CLKS_PER_BIT_SLOW=4, CLKS_PER_BIT_FAST=2 and PULSE_LEN=3. The windows are therefore 32 and 16 cycles, short enough to sweep every burst length from zero past two full window-plus-pulse periods at both rates. Each burst's pulse count, first pulse cycle and media gating are compared against figures worked out arithmetically. The same small windows make it cheap to hit interrupted bursts, a rate switch in the middle of a burst, and flag set and clear collisions at exact cycles.

// File: rtl/txwd_pkg.sv
package txwd_pkg;

  typedef enum logic {
    WD_ARMED = 1'b0,
    WD_PULSE = 1'b1
  } wdState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic countInc;   // advance the active-run counter
    logic countClr;   // return the active-run counter to zero
    logic pulseLoad;  // start a reset pulse
    logic pulseRun;   // advance the pulse-length counter
  } wdStrobes_t;

endpackage

// File: rtl/txwd_datapath.sv
module txwd_datapath
  import txwd_pkg::*;
#(
  parameter int BIT_PERIODS       = 8192,
  parameter int CLKS_PER_BIT_SLOW = 8,
  parameter int CLKS_PER_BIT_FAST = 4,
  parameter int PULSE_LEN         = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rateFast,
  input  wdStrobes_t stb,
  output logic       atLimit,
  output logic       rateChanged,
  output logic       pulseDone
);

  localparam int THR_SLOW = BIT_PERIODS * CLKS_PER_BIT_SLOW;
  localparam int THR_FAST = BIT_PERIODS * CLKS_PER_BIT_FAST;
  localparam int THR_MAX  = (THR_SLOW > THR_FAST) ? THR_SLOW : THR_FAST;
  localparam int CNT_W    = $clog2(THR_MAX + 1);
  localparam int PULSE_W  = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0]   LIM_SLOW = CNT_W'(THR_SLOW - 1);
  localparam logic [CNT_W-1:0]   LIM_FAST = CNT_W'(THR_FAST - 1);
  localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0]   runCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               rateQ;
  logic [CNT_W-1:0]   curLimit;

  // Active-run counter
  always_ff @(posedge clk) begin
    if (!rstN)              runCnt <= '0;
    else if (stb.countClr)  runCnt <= '0;
    else if (stb.countInc)  runCnt <= runCnt + 1'b1;
  end

  // Previous rate, for change detection
  always_ff @(posedge clk) begin
    if (!rstN) rateQ <= rateFast;
    else       rateQ <= rateFast;
  end

  // Pulse-length counter
  always_ff @(posedge clk) begin
    if (!rstN)              pulseCnt <= '0;
    else if (stb.pulseLoad) pulseCnt <= '0;
    else if (stb.pulseRun)  pulseCnt <= pulseCnt + 1'b1;
  end

  always_comb begin
    curLimit    = rateFast ? LIM_FAST : LIM_SLOW;
    atLimit     = (runCnt == curLimit);
    rateChanged = (rateFast != rateQ);
    pulseDone   = (pulseCnt == PULSE_LAST);
  end

  // R2: the run counter never reaches the larger threshold
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < CNT_W'(THR_MAX));

  // R11: a rate switch leaves the counter at zero
  assert_rate_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    rateChanged |=> (runCnt == '0));

endmodule

// File: rtl/txwd_control.sv
module txwd_control
  import txwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txActive,
  input  logic       hubEnable,
  input  logic       atLimit,
  input  logic       rateChanged,
  input  logic       pulseDone,
  input  logic       flagClearWr,
  input  logic       flagClearData,
  input  logic       swReset,
  output wdStrobes_t stb,
  output logic       pulseActive,
  output logic       mediaArm,
  output logic       timeoutFlag
);

  wdState_t state;
  wdState_t stateNext;
  logic     armed;
  logic     counting;
  logic     fire;
  logic     flagClear;

  always_comb begin
    armed     = (state == WD_ARMED);
    counting  = armed && txActive && !rateChanged;
    fire      = counting && atLimit;
    flagClear = swReset || (flagClearWr && flagClearData);

    stb.countInc  = counting && !atLimit;
    stb.countClr  = !counting || atLimit;
    stb.pulseLoad = fire;
    stb.pulseRun  = !armed;

    stateNext = state;
    case (state)
      WD_ARMED: if (fire)      stateNext = WD_PULSE;
      WD_PULSE: if (pulseDone) stateNext = WD_ARMED;
      default:                 stateNext = WD_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= WD_ARMED;
    else       state <= stateNext;
  end

  // Hub-enable captured at the timeout edge, held for the whole pulse
  always_ff @(posedge clk) begin
    if (!rstN)     mediaArm <= 1'b0;
    else if (fire) mediaArm <= hubEnable;
  end

  // Sticky flag; a timeout outranks a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN)          timeoutFlag <= 1'b0;
    else if (fire)      timeoutFlag <= 1'b1;
    else if (flagClear) timeoutFlag <= 1'b0;
  end

  assign pulseActive = !armed;

  // R5: the pulse holds until the length counter reports its last cycle
  assert_pulse_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && !pulseDone) |=> pulseActive);

  // R10: a software reset without a timeout empties the flag
  assert_swreset_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (swReset && !(armed && txActive && !rateChanged && atLimit)) |=> !timeoutFlag);

endmodule

// File: rtl/tx_hang_watchdog.sv
module tx_hang_watchdog
  import txwd_pkg::*;
#(
  parameter int BIT_PERIODS       = 8192,
  parameter int CLKS_PER_BIT_SLOW = 8,
  parameter int CLKS_PER_BIT_FAST = 4,
  parameter int PULSE_LEN         = 16,
  parameter int MEDIA_UNITS       = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rateFast,
  input  logic                   hubEnable,
  input  logic                   txActive,
  input  logic                   flagClearWr,
  input  logic                   flagClearData,
  input  logic                   swReset,
  output logic                   hubReset,
  output logic [MEDIA_UNITS-1:0] mediaReset,
  output logic                   timeoutFlag
);

  wdStrobes_t stb;
  logic atLimit;
  logic rateChanged;
  logic pulseDone;
  logic pulseActive;
  logic mediaArm;

  txwd_datapath #(
    .BIT_PERIODS      (BIT_PERIODS),
    .CLKS_PER_BIT_SLOW(CLKS_PER_BIT_SLOW),
    .CLKS_PER_BIT_FAST(CLKS_PER_BIT_FAST),
    .PULSE_LEN        (PULSE_LEN)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .rateFast   (rateFast),
    .stb        (stb),
    .atLimit    (atLimit),
    .rateChanged(rateChanged),
    .pulseDone  (pulseDone)
  );

  txwd_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .txActive     (txActive),
    .hubEnable    (hubEnable),
    .atLimit      (atLimit),
    .rateChanged  (rateChanged),
    .pulseDone    (pulseDone),
    .flagClearWr  (flagClearWr),
    .flagClearData(flagClearData),
    .swReset      (swReset),
    .stb          (stb),
    .pulseActive  (pulseActive),
    .mediaArm     (mediaArm),
    .timeoutFlag  (timeoutFlag)
  );

  assign hubReset = pulseActive;

  for (genvar g = 0; g < MEDIA_UNITS; g++) begin : gen_media
    assign mediaReset[g] = pulseActive && mediaArm;
  end

  // R4: an inactive sample forbids a pulse from starting next cycle
  assert_gap_no_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |=> !$rose(hubReset));

  // R6: media resets only ever accompany the hub reset
  assert_media_with_hub_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|mediaReset) |-> hubReset);

  // R8: the flag is up whenever a pulse begins
  assert_flag_on_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hubReset) |-> timeoutFlag);

endmodule

// File: tb/tx_hang_watchdog_bench.sv
module tx_hang_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BITS  = 8;
  localparam int CPB_S = 4;
  localparam int CPB_F = 2;
  localparam int PL    = 3;
  localparam int THR_S = BITS * CPB_S;
  localparam int THR_F = BITS * CPB_F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rateFast = 1'b0;
  logic hubEnable = 1'b1;
  logic txActive = 1'b0;
  logic flagClearWr = 1'b0;
  logic flagClearData = 1'b0;
  logic swReset = 1'b0;
  logic hubReset;
  logic [1:0] mediaReset;
  logic timeoutFlag;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tx_hang_watchdog #(
    .BIT_PERIODS(BITS), .CLKS_PER_BIT_SLOW(CPB_S), .CLKS_PER_BIT_FAST(CPB_F),
    .PULSE_LEN(PL), .MEDIA_UNITS(2)
  ) u_tx_hang_watchdog (
    .clk(clk), .rstN(rstN), .rateFast(rateFast), .hubEnable(hubEnable),
    .txActive(txActive), .flagClearWr(flagClearWr), .flagClearData(flagClearData),
    .swReset(swReset), .hubReset(hubReset), .mediaReset(mediaReset),
    .timeoutFlag(timeoutFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    txActive = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clearFlag();
    flagClearWr = 1'b1; flagClearData = 1'b1;
    tick();
    flagClearWr = 1'b0; flagClearData = 1'b0;
  endtask

  // Active for a samples, one inactive sample, then active for b samples
  task automatic runPattern(input int a, input int b, output int first,
                            output int hubCnt, output int m0, output int m1);
    first = 0; hubCnt = 0; m0 = 0; m1 = 0;
    for (int i = 1; i <= a + b + PL + 5; i++) begin
      txActive = (i <= a) || (i > a + 1 && i <= a + 1 + b);
      tick();
      if (hubReset) begin
        hubCnt++;
        if (first == 0) first = i;
      end
      m0 += int'(mediaReset[0]);
      m1 += int'(mediaReset[1]);
    end
    txActive = 1'b0;
  endtask

  // Number of timeouts for a continuous burst of n samples
  function automatic int expPulses(input int n, input int thr);
    int k = 0;
    while ((k + 1) * thr + k * PL <= n) k++;
    return k;
  endfunction

  task automatic sweep(input bit fast, input string req);
    int thr = fast ? THR_F : THR_S;
    int first, hubCnt, m0, m1, k, expM;
    rateFast = fast;
    idle(PL + 3);
    clearFlag();
    for (int n = 0; n <= 2 * thr + PL + 3; n++) begin
      hubEnable = n[0];
      runPattern(n, 0, first, hubCnt, m0, m1);
      k = expPulses(n, thr);
      expM = hubEnable ? k * PL : 0;
      chk({req, " first pulse cycle"}, first, (k > 0) ? thr : 0);
      chk("R5/R7 pulse cycles", hubCnt, k * PL);
      chk("R6 media0 cycles", m0, expM);
      chk("R6 media1 cycles", m1, expM);
      chk("R8 flag after burst", int'(timeoutFlag), (k > 0) ? 1 : 0);
      idle(2);
      clearFlag();
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    miscompares++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stimulus
    int first, hubCnt, m0, m1;
    @(negedge clk);
    tick();
    // R1: reset state
    chk("R1 hubReset in reset", int'(hubReset), 0);
    chk("R1 mediaReset in reset", int'(mediaReset), 0);
    chk("R1 flag in reset", int'(timeoutFlag), 0);
    rstN = 1'b1;
    tick();
    chk("R1 hubReset after reset", int'(hubReset), 0);
    chk("R1 flag after reset", int'(timeoutFlag), 0);

    // R2 and R3: burst-length sweeps at both rates
    sweep(1'b0, "R2");
    sweep(1'b1, "R3");

    // R4: an interrupted run never times out
    rateFast = 1'b0; hubEnable = 1'b1;
    idle(PL + 3); clearFlag();
    runPattern(THR_S - 1, THR_S - 1, first, hubCnt, m0, m1);
    chk("R4 split run pulses", hubCnt, 0);
    chk("R4 split run flag", int'(timeoutFlag), 0);
    runPattern(THR_S - 1, THR_S, first, hubCnt, m0, m1);
    chk("R4 restart first pulse", first, 2 * THR_S);
    chk("R4 restart pulse cycles", hubCnt, PL);

    // R7: held active gives pulses spaced by threshold plus pulse length
    idle(PL + 3); clearFlag();
    rateFast = 1'b1;
    idle(2);
    runPattern(3 * THR_F + 2 * PL, 0, first, hubCnt, m0, m1);
    chk("R7 rearm pulse count", hubCnt, 3 * PL);

    // R11: rate switch mid-burst clears the count
    idle(PL + 3); clearFlag();
    rateFast = 1'b0;
    idle(2);
    first = 0;
    for (int i = 1; i <= 40; i++) begin
      txActive = 1'b1;
      rateFast = (i >= 6);
      tick();
      if (hubReset && first == 0) first = i;
    end
    chk("R11 first pulse after rate switch", first, 6 + THR_F);
    idle(PL + 3);

    // R8, R9: flag stays, write 0 ignored, write 1 clears
    clearFlag();
    runPattern(THR_F, 0, first, hubCnt, m0, m1);
    idle(4);
    chk("R8 flag sticky after pulse", int'(timeoutFlag), 1);
    flagClearWr = 1'b1; flagClearData = 1'b0;
    tick();
    flagClearWr = 1'b0;
    chk("R9 write 0 keeps flag", int'(timeoutFlag), 1);
    flagClearData = 1'b1;
    tick();
    chk("R9 data without strobe keeps flag", int'(timeoutFlag), 1);
    flagClearWr = 1'b1;
    tick();
    flagClearWr = 1'b0; flagClearData = 1'b0;
    chk("R9 write 1 clears flag", int'(timeoutFlag), 0);

    // R10: software reset clears; timeout on the same edge wins
    runPattern(THR_F, 0, first, hubCnt, m0, m1);
    chk("R10 flag set before swReset", int'(timeoutFlag), 1);
    swReset = 1'b1;
    tick();
    swReset = 1'b0;
    chk("R10 swReset clears flag", int'(timeoutFlag), 0);
    idle(2);
    for (int i = 1; i <= THR_F; i++) begin
      txActive = 1'b1;
      swReset = (i == THR_F);
      tick();
    end
    swReset = 1'b0; txActive = 1'b0;
    chk("R10 timeout beats swReset", int'(timeoutFlag), 1);
    chk("R10 pulse running", int'(hubReset), 1);
    idle(PL + 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule